// File: doc/BRIEF.md
# Microprogrammed Accumulator Processor Controller

This block is a small accumulator processor whose sequencing comes from a control store rather than from a hand-built state machine. A control address register picks one horizontal microword per clock. Each microword carries two encoded micro-operation fields, a test condition, a branch kind and a 7-bit target. Both micro-operations of a word act on the datapath registers (program counter, memory address, memory buffer, instruction and accumulator) in the same clock. A one-deep return register lets an execution routine call the shared operand-indirection routine and come back.

Every macro instruction begins with a three-word fetch routine at control address 0. Its last word loads the instruction register and branches through a mapping step to the execution routine of the opcode. That routine starts at 64 plus four times the opcode. A word-addressed memory holds program and data. Another agent loads it through a load port while reset is held, and reads it through a peek port. The processor runs from address 0 after reset and parks when it reaches a halt instruction.

Top module: `ucpu_top`

## Requirements
- R1: While reset is asserted the program counter and accumulator read 0 and the halt flag is low. The control address is 0, so execution restarts with fetch.
- R2: Fetch takes three microwords. First the address register takes the program counter. Then the memory word is read while the program counter steps by one. Then the instruction register is loaded, and control maps to address 64 + 4·opcode.
- R3: Both micro-operations in one microword take effect in the same clock edge. An example is the memory read paired with the program counter increment.
- R4: Opcode 0 loads the accumulator from memory and opcode 1 stores it to memory. Opcode 2 adds a memory word to it and opcode 3 subtracts one from it. All arithmetic is modulo 2^16.
- R5: When bit 15 (indirect) of an instruction is 1, the execution routine calls the indirection routine. That routine replaces the instruction's address field with the low 11 bits of the memory word it points to, then returns through the return register to the next microword of the caller.
- R6: Opcode 4 sets the program counter to the effective address unconditionally.
- R7: Opcode 6 branches to the effective address only when the accumulator is zero. Opcode 7 branches only when accumulator bit 15 is 1.
- R8: Opcode 5 halts. Opcodes 8 to 15 do nothing and execution continues with the next instruction.
- R9: Once halted, the halt flag stays high, the program counter stays fixed and memory receives no writes.
- R10: An instruction word is laid out as bit 15 for indirection, bits 14..11 for the opcode and bits 10..0 for the address. Memory is indexed by the low MEM_AW bits of an address.
- R11: The load port writes a memory word on a clock edge while loadEn is high. The peek port returns the addressed word combinationally.
- R12: When a microword's condition is false, the control address steps by one whatever the branch kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Write loadData into memory at loadAddr |
| loadAddr | input | MEM_AW | Memory word address for loading |
| loadData | input | 16 | Word to load |
| peekAddr | input | MEM_AW | Memory word address to observe |
| peekData | output | 16 | Memory word at peekAddr |
| acOut | output | 16 | Accumulator |
| pcOut | output | 11 | Program counter |
| halted | output | 1 | High while parked on the halt routine |

## Verification
The hardest paths to reach from the ports are the nested control flow paths. One is an indirect operand that enters the indirection routine through the return register. Another is a conditional branch whose condition is false, so the control address simply steps. The bench reaches them with one fixed program that uses indirect subtract, indirect store and indirect jump, then takes a sign test and a zero test whose outcomes depend on the data. It sweeps a grid of operand values chosen so that both outcomes of each test occur, sign and wrap-around included. For every grid point it predicts the stored words, the final accumulator and the final program counter by arithmetic.

// File: rtl/ucpu_pkg.sv
package ucpu_pkg;

  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 11;
  localparam int OP_W    = 4;
  localparam int UADDR_W = 7;

  localparam logic [OP_W-1:0] OP_LOAD = 4'd0;
  localparam logic [OP_W-1:0] OP_STA  = 4'd1;
  localparam logic [OP_W-1:0] OP_ADD  = 4'd2;
  localparam logic [OP_W-1:0] OP_SUB  = 4'd3;
  localparam logic [OP_W-1:0] OP_BUN  = 4'd4;
  localparam logic [OP_W-1:0] OP_HALT = 4'd5;
  localparam logic [OP_W-1:0] OP_BZA  = 4'd6;
  localparam logic [OP_W-1:0] OP_BNA  = 4'd7;

  localparam int EXEC_BASE = 64;
  localparam int SLOTS     = 4;
  localparam int INDIR_AT  = 8;
  localparam logic [UADDR_W-1:0] HALT_UADDR = UADDR_W'(EXEC_BASE + SLOTS*5);

  typedef enum logic [2:0] {
    F1_NOP, F1_MAR_PC, F1_MAR_IR, F1_ADD, F1_READ, F1_AC_MBR, F1_IR_MBR, F1_WRITE
  } f1_e;

  typedef enum logic [2:0] {
    F2_NOP, F2_INC_PC, F2_MBR_AC, F2_MBR_PC, F2_PC_MBR, F2_IRA_MBR, F2_SUB, F2_PC_IR
  } f2_e;

  typedef enum logic [1:0] {C_ALWAYS, C_IBIT, C_ZERO, C_NEG} cond_e;
  typedef enum logic [1:0] {B_JMP, B_CALL, B_RET, B_MAP} br_e;

  typedef struct packed {
    f1_e                f1;
    f2_e                f2;
    cond_e              cond;
    br_e                br;
    logic [UADDR_W-1:0] addr;
  } uword_t;

  typedef struct packed {
    logic marFromPc;
    logic marFromIr;
    logic acAdd;
    logic memRead;
    logic acFromMbr;
    logic irFromMbr;
    logic memWrite;
    logic pcInc;
    logic mbrFromAc;
    logic mbrFromPc;
    logic pcFromMbr;
    logic irAddrFromMbr;
    logic acSub;
    logic pcFromIr;
  } strobe_t;

  typedef struct packed {
    logic            iBit;
    logic [OP_W-1:0] opcode;
    logic            acZero;
    logic            acNeg;
  } status_t;

  function automatic uword_t mk(f1_e a, f2_e b, cond_e c, br_e d, int n);
    uword_t w;
    w.f1   = a;
    w.f2   = b;
    w.cond = c;
    w.br   = d;
    w.addr = UADDR_W'(n);
    return w;
  endfunction

  function automatic int ex(logic [OP_W-1:0] op, int slot);
    return EXEC_BASE + SLOTS*int'(op) + slot;
  endfunction

  // Control store contents; unlisted words fall back to fetch.
  function automatic uword_t uromWord(logic [UADDR_W-1:0] a);
    int ia;
    ia = int'(a);
    if (ia == 0)               return mk(F1_MAR_PC, F2_NOP,     C_ALWAYS, B_JMP, 1);
    if (ia == 1)               return mk(F1_READ,   F2_INC_PC,  C_ALWAYS, B_JMP, 2);
    if (ia == 2)               return mk(F1_IR_MBR, F2_NOP,     C_ALWAYS, B_MAP, 0);
    if (ia == INDIR_AT)        return mk(F1_MAR_IR, F2_NOP,     C_ALWAYS, B_JMP, INDIR_AT+1);
    if (ia == INDIR_AT+1)      return mk(F1_READ,   F2_NOP,     C_ALWAYS, B_JMP, INDIR_AT+2);
    if (ia == INDIR_AT+2)      return mk(F1_NOP,    F2_IRA_MBR, C_ALWAYS, B_RET, 0);
    // memory-operand opcodes share slots 0..2
    if (ia == ex(OP_LOAD,0) || ia == ex(OP_STA,0) || ia == ex(OP_ADD,0) ||
        ia == ex(OP_SUB,0)  || ia == ex(OP_BUN,0) || ia == ex(OP_BZA,0) ||
        ia == ex(OP_BNA,0))    return mk(F1_NOP,    F2_NOP,     C_IBIT,   B_CALL, INDIR_AT);
    if (ia == ex(OP_LOAD,1) || ia == ex(OP_STA,1) || ia == ex(OP_ADD,1) ||
        ia == ex(OP_SUB,1))    return mk(F1_MAR_IR, F2_NOP,     C_ALWAYS, B_JMP, ia+1);
    if (ia == ex(OP_LOAD,2) || ia == ex(OP_ADD,2) || ia == ex(OP_SUB,2))
                               return mk(F1_READ,   F2_NOP,     C_ALWAYS, B_JMP, ia+1);
    if (ia == ex(OP_STA,2))    return mk(F1_NOP,    F2_MBR_AC,  C_ALWAYS, B_JMP, ia+1);
    if (ia == ex(OP_LOAD,3))   return mk(F1_AC_MBR, F2_NOP,     C_ALWAYS, B_JMP, 0);
    if (ia == ex(OP_STA,3))    return mk(F1_WRITE,  F2_NOP,     C_ALWAYS, B_JMP, 0);
    if (ia == ex(OP_ADD,3))    return mk(F1_ADD,    F2_NOP,     C_ALWAYS, B_JMP, 0);
    if (ia == ex(OP_SUB,3))    return mk(F1_NOP,    F2_SUB,     C_ALWAYS, B_JMP, 0);
    if (ia == ex(OP_BUN,1))    return mk(F1_NOP,    F2_PC_IR,   C_ALWAYS, B_JMP, 0);
    if (ia == ex(OP_HALT,0))   return mk(F1_NOP,    F2_NOP,     C_ALWAYS, B_JMP, ia);
    if (ia == ex(OP_BZA,1))    return mk(F1_NOP,    F2_NOP,     C_ZERO,   B_JMP, ia+2);
    if (ia == ex(OP_BNA,1))    return mk(F1_NOP,    F2_NOP,     C_NEG,    B_JMP, ia+2);
    if (ia == ex(OP_BZA,2) || ia == ex(OP_BNA,2))
                               return mk(F1_NOP,    F2_NOP,     C_ALWAYS, B_JMP, 0);
    if (ia == ex(OP_BZA,3) || ia == ex(OP_BNA,3))
                               return mk(F1_NOP,    F2_PC_IR,   C_ALWAYS, B_JMP, 0);
    return mk(F1_NOP, F2_NOP, C_ALWAYS, B_JMP, 0);
  endfunction

endpackage

// File: rtl/ucpu_mem.sv
module ucpu_mem #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [DW-1:0] wData,
  input  logic [AW-1:0] rAddrA,
  output logic [DW-1:0] rDataA,
  input  logic [AW-1:0] rAddrB,
  output logic [DW-1:0] rDataB
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wAddr] <= wData;
  end

  assign rDataA = cells[rAddrA];
  assign rDataB = cells[rAddrB];
endmodule

// File: rtl/ucpu_ctrl.sv
module ucpu_ctrl
  import ucpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  status_t status,
  output strobe_t strobes,
  output logic    halted
);
  logic [UADDR_W-1:0] car, sbr, carNext, carInc;
  uword_t             uw;
  logic               condTrue;

  assign uw     = uromWord(car);
  assign carInc = car + 1'b1;

  always_comb begin
    strobes           = '0;
    strobes.marFromPc = (uw.f1 == F1_MAR_PC);
    strobes.marFromIr = (uw.f1 == F1_MAR_IR);
    strobes.acAdd     = (uw.f1 == F1_ADD);
    strobes.memRead   = (uw.f1 == F1_READ);
    strobes.acFromMbr = (uw.f1 == F1_AC_MBR);
    strobes.irFromMbr = (uw.f1 == F1_IR_MBR);
    strobes.memWrite  = (uw.f1 == F1_WRITE);
    strobes.pcInc         = (uw.f2 == F2_INC_PC);
    strobes.mbrFromAc     = (uw.f2 == F2_MBR_AC);
    strobes.mbrFromPc     = (uw.f2 == F2_MBR_PC);
    strobes.pcFromMbr     = (uw.f2 == F2_PC_MBR);
    strobes.irAddrFromMbr = (uw.f2 == F2_IRA_MBR);
    strobes.acSub         = (uw.f2 == F2_SUB);
    strobes.pcFromIr      = (uw.f2 == F2_PC_IR);
  end

  always_comb begin
    unique case (uw.cond)
      C_ALWAYS: condTrue = 1'b1;
      C_IBIT:   condTrue = status.iBit;
      C_ZERO:   condTrue = status.acZero;
      C_NEG:    condTrue = status.acNeg;
    endcase
  end

  always_comb begin
    carNext = carInc;
    if (condTrue) begin
      unique case (uw.br)
        B_JMP:  carNext = uw.addr;
        B_CALL: carNext = uw.addr;
        B_RET:  carNext = sbr;
        B_MAP:  carNext = UADDR_W'(EXEC_BASE) | UADDR_W'({status.opcode, 2'b00});
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car <= '0;
      sbr <= '0;
    end else begin
      car <= carNext;
      if (condTrue && uw.br == B_CALL) sbr <= carInc;
    end
  end

  assign halted = (car == HALT_UADDR);

  p_map_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (condTrue && uw.br == B_MAP) |=> (car[UADDR_W-1] && car[1:0] == 2'b00));

  p_ret_resumes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (condTrue && uw.br == B_RET) |=> (car == $past(sbr)));

  p_call_saves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (condTrue && uw.br == B_CALL) |=> (sbr == $past(car) + 1'b1));

  p_false_steps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!condTrue) |=> (car == $past(car) + 1'b1));

  p_halt_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
endmodule

// File: rtl/ucpu_datapath.sv
module ucpu_datapath
  import ucpu_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  output status_t           status,
  input  logic              loadEn,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [MEM_AW-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData,
  output logic [DATA_W-1:0] acOut,
  output logic [ADDR_W-1:0] pcOut
);
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mbr, ac, ir, memQ, irSrc, memWData;
  logic [ADDR_W-1:0] irAddr;
  logic              memWe;
  logic [MEM_AW-1:0] memWAddr;

  assign irAddr   = ir[ADDR_W-1:0];
  assign memWe    = loadEn | strobes.memWrite;
  assign memWAddr = loadEn ? loadAddr : mar[MEM_AW-1:0];
  assign memWData = loadEn ? loadData : mbr;

  ucpu_mem #(.DW(DATA_W), .AW(MEM_AW)) u_mem (
    .clk    (clk),
    .we     (memWe),
    .wAddr  (memWAddr),
    .wData  (memWData),
    .rAddrA (mar[MEM_AW-1:0]),
    .rDataA (memQ),
    .rAddrB (peekAddr),
    .rDataB (peekData)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ac  <= '0;
      ir  <= '0;
    end else begin
      if (strobes.marFromPc)      mar <= pc;
      else if (strobes.marFromIr) mar <= irAddr;

      if (strobes.memRead)        mbr <= memQ;
      else if (strobes.mbrFromAc) mbr <= ac;
      else if (strobes.mbrFromPc) mbr <= DATA_W'(pc);

      if (strobes.acAdd)          ac <= ac + mbr;
      else if (strobes.acSub)     ac <= ac - mbr;
      else if (strobes.acFromMbr) ac <= mbr;

      if (strobes.irFromMbr)          ir <= mbr;
      else if (strobes.irAddrFromMbr) ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];

      if (strobes.pcInc)          pc <= pc + 1'b1;
      else if (strobes.pcFromMbr) pc <= mbr[ADDR_W-1:0];
      else if (strobes.pcFromIr)  pc <= irAddr;
    end
  end

  // Mapping sees the word entering IR in the same microword.
  assign irSrc         = strobes.irFromMbr ? mbr : ir;
  assign status.iBit   = irSrc[DATA_W-1];
  assign status.opcode = irSrc[DATA_W-2 -: OP_W];
  assign status.acZero = (ac == '0);
  assign status.acNeg  = ac[DATA_W-1];

  assign acOut = ac;
  assign pcOut = pc;

  p_dual_uop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.memRead && strobes.pcInc) |=>
      (pc == $past(pc) + 1'b1) && (mbr == $past(memQ)));

  p_ac_writer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.acAdd, strobes.acSub, strobes.acFromMbr}));

  p_mbr_writer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.memRead, strobes.mbrFromAc, strobes.mbrFromPc}));

  p_ir_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.irFromMbr, strobes.irAddrFromMbr}));

  p_sub_wraps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.acSub |=> (ac + $past(mbr) == $past(ac)));

  p_indirect_keeps_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.irAddrFromMbr |=> (ir[DATA_W-1:ADDR_W] == $past(ir[DATA_W-1:ADDR_W])));
endmodule

// File: rtl/ucpu_top.sv
module ucpu_top
  import ucpu_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadEn,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [15:0]       loadData,
  input  logic [MEM_AW-1:0] peekAddr,
  output logic [15:0]       peekData,
  output logic [15:0]       acOut,
  output logic [10:0]       pcOut,
  output logic              halted
);
  strobe_t strobes;
  status_t status;

  ucpu_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (status),
    .strobes (strobes),
    .halted  (halted)
  );

  ucpu_datapath #(.MEM_AW(MEM_AW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .status   (status),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .peekAddr (peekAddr),
    .peekData (peekData),
    .acOut    (acOut),
    .pcOut    (pcOut)
  );

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (!strobes.memWrite && pcOut == $past(pcOut)));
endmodule

// File: tb/ucpu_top_tb.sv
module ucpu_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 8;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              loadEn = 1'b0;
  logic [MEM_AW-1:0] loadAddr = '0;
  logic [15:0]       loadData = '0;
  logic [MEM_AW-1:0] peekAddr = '0;
  logic [15:0]       peekData, acOut;
  logic [10:0]       pcOut;
  logic              halted;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucpu_top #(.MEM_AW(MEM_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .peekAddr(peekAddr), .peekData(peekData),
    .acOut(acOut), .pcOut(pcOut), .halted(halted)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R9 watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // R10: {I, opcode[3:0], address[10:0]}
  function automatic logic [15:0] instr(logic i, logic [3:0] op, logic [10:0] a);
    return {i, op, a};
  endfunction

  task automatic put(logic [MEM_AW-1:0] a, logic [15:0] d);
    @(negedge clk);
    loadEn   = 1'b1;
    loadAddr = a;
    loadData = d;
    @(negedge clk);
    loadEn   = 1'b0;
  endtask

  task automatic peek(logic [MEM_AW-1:0] a, output logic [15:0] d);
    @(negedge clk);
    peekAddr = a;
    #1 d = peekData;
  endtask

  task automatic runCase(logic [15:0] x, logic [15:0] y, logic [15:0] z, logic [15:0] w);
    logic [15:0] s, dd, sel, t, expAc, expM52, got;
    logic [10:0] expPc, pcAtHalt;
    bit done;
    @(negedge clk);
    rst_n = 1'b0;
    put(0,  instr(0, 4'd0, 11'h040));   // LOAD x
    put(1,  instr(0, 4'd2, 11'h041));   // ADD y
    put(2,  instr(0, 4'd1, 11'h050));   // STA sum
    put(3,  instr(1, 4'd3, 11'h042));   // SUB indirect z
    put(4,  instr(1, 4'd1, 11'h044));   // STA indirect
    put(5,  instr(0, 4'd7, 11'd8));     // BNA 8
    put(6,  instr(0, 4'd0, 11'h045));   // LOAD 1
    put(7,  instr(1, 4'd4, 11'h049));   // BUN indirect -> 9
    put(8,  instr(0, 4'd0, 11'h046));   // LOAD 2
    put(9,  instr(0, 4'd3, 11'h047));   // SUB w
    put(10, instr(0, 4'd6, 11'd14));    // BZA 14
    put(11, instr(0, 4'd1, 11'h052));   // STA
    put(12, 16'hFFFF);                  // undefined opcode 15, indirect
    put(13, instr(0, 4'd5, 11'd0));     // HALT
    put(14, instr(0, 4'd0, 11'h048));   // LOAD 7
    put(15, instr(0, 4'd1, 11'h052));   // STA
    put(16, instr(0, 4'd5, 11'd0));     // HALT
    put(8'h40, x);      put(8'h41, y);
    put(8'h42, 16'h8043); put(8'h43, z);
    put(8'h44, 16'hF851); put(8'h45, 16'd1);
    put(8'h46, 16'd2);  put(8'h47, w);
    put(8'h48, 16'd7);  put(8'h49, 16'hA009);
    put(8'h50, 16'h0); put(8'h51, 16'h0); put(8'h52, 16'h0);
    put(8'h53, 16'hA5A5);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b0;
    for (int n = 0; n < 3000 && !done; n++) begin
      @(negedge clk);
      if (halted) done = 1'b1;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 no halt: actual halted=%0b expected 1", halted);
      return;
    end
    s   = x + y;
    dd  = s - z;
    sel = dd[15] ? 16'd2 : 16'd1;
    t   = sel - w;
    if (t == 16'd0) begin
      expAc = 16'd7; expM52 = 16'd7; expPc = 11'd17;
    end else begin
      expAc = t;     expM52 = t;     expPc = 11'd14;
    end
    pcAtHalt = pcOut;
    check("R2 R3 R4 R10 R12 final AC", {16'h0, acOut}, {16'h0, expAc});
    check("R6/R8 final PC", {21'h0, pcOut}, {21'h0, expPc});
    repeat (10) @(negedge clk);
    check("R9 halt held", {31'h0, halted}, 32'd1);
    check("R9 PC frozen", {21'h0, pcOut}, {21'h0, pcAtHalt});
    peek(8'h50, got); check("R4 stored sum", {16'h0, got}, {16'h0, s});
    peek(8'h51, got); check("R5 indirect sub/store", {16'h0, got}, {16'h0, dd});
    peek(8'h52, got); check("R7 branch result", {16'h0, got}, {16'h0, expM52});
    peek(8'h53, got); check("R11 untouched word", {16'h0, got}, 32'h0000A5A5);
  endtask

  initial begin
    logic [15:0] xs [5];
    logic [15:0] ys [3];
    logic [15:0] zs [3];
    logic [15:0] ws [3];
    xs = '{16'h0000, 16'h0001, 16'h7FFF, 16'hFFFF, 16'h1234};
    ys = '{16'h0000, 16'h0001, 16'h8000};
    zs = '{16'h0000, 16'h0005, 16'hFFFF};
    ws = '{16'h0000, 16'h0001, 16'h0002};
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset PC", {21'h0, pcOut}, 32'd0);
    check("R1 reset AC", {16'h0, acOut}, 32'd0);
    check("R1 reset halted", {31'h0, halted}, 32'd0);
    put(8'h20, 16'hBEEF);
    begin
      logic [15:0] got;
      peek(8'h20, got);
      check("R11 load then peek", {16'h0, got}, 32'h0000BEEF);
    end
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          for (int d = 0; d < 3; d++)
            runCase(xs[a], ys[b], zs[c], ws[d]);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule